// File: doc/BRIEF.md
# Display controller register interface

This block is the 32-bit memory-mapped register slave of a framebuffer display controller. It decodes aligned word accesses from a simple request/response bus. It holds the screen geometry, the frame start offset, the control word and the cursor position, and it presents them as plain outputs to the pixel pipeline. The pixel depth is decoded from a three-bit field of the control word. The three-entry cursor palette and the 512-word cursor pattern are stored in the block and can be read back. Colour palette writes leave the block as a one-cycle strobe that carries an index and an RGB triple, so the colour table can sit beside the video datapath.

The geometry registers use scaled encodings. Width is programmed in units of four pixels. Height is programmed as twice the line count. Writes to the video timing addresses are accepted and have no effect. A write to the soft-reset address returns the whole register state to its power-on values. An interrupt line is set by a frame-done pulse from the display engine and is cleared by any register write.

Top module: `dispctl_regs`

## Requirements
- R1: A word write to byte offset 0x010 sets the width output to the written value times 4, truncated to WID_W bits. A read of 0x010 returns the stored width divided by 4.
- R2: A word write to 0x014 sets the height output to the written value divided by 2 (rounded down). A read of 0x014 returns the stored height times 2.
- R3: The depth output follows control word bits 22:20. Codes 0 to 5 give 1, 2, 4, 8, 15 and 16. Codes 6 and 7 give 0.
- R4: A word write inside the colour palette window (0x800 to 0xFFF) raises the palette write strobe for exactly one cycle. The strobe carries index (offset−0x800)>>3 and write-data bits 23:0 as the RGB value (red 23:16, green 15:8, blue 7:0). Reads of this window return 0.
- R5: The cursor palette (0x100 to 0x117, three entries) and the cursor pattern (0x1000 to 0x1FFF, 512 entries) use an 8-byte stride, with index (offset−base)>>3. A write stores write-data bits 23:0 (palette) or bits 15:0 (pattern). A read returns the stored entry zero-extended, and both words of a stride reach the same entry.
- R6: The control word (0x018) is stored whole and reads back unchanged. The start offset (0x01C) and the cursor position (0x020) drive their outputs: cursor X is bits 23:12 of the position and cursor Y is bits 11:0. Reads of 0x01C and 0x020 return 0.
- R7: Word writes to the timing addresses 0x040 to 0x07C change no stored state and raise no strobe. Reads of these addresses return 0.
- R8: A read of any address that is not readable returns 0.
- R9: Hardware reset and a word write to 0x024 both clear the width, height, control word, start offset, cursor position, cursor palette, cursor pattern and interrupt. The soft-reset write also raises the colour-table clear output for one cycle.
- R10: A frame-done pulse sets the interrupt on the next cycle. Any aligned word write clears it. If a frame-done pulse and a write arrive in the same cycle, the interrupt is set.
- R11: An access whose size code is not 2 (word), or whose address is not word aligned, changes no state and leaves the interrupt as it was. A read of this kind returns 0.
- R12: Every request cycle gets a response valid in the following cycle, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | Size code, 2 = 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| frame_done | input | 1 | Display update finished |
| irq | output | 1 | Interrupt line |
| scr_width | output | WID_W | Screen width in pixels |
| scr_height | output | HGT_W | Screen height in lines |
| scr_start | output | 32 | Frame start offset |
| ctrl_word | output | 32 | Control word |
| pix_depth | output | 5 | Decoded bits per pixel |
| cur_x | output | CUR_W | Cursor column |
| cur_y | output | CUR_W | Cursor row |
| clut_we | output | 1 | Colour palette write strobe |
| clut_idx | output | log2(CLUT_N) | Colour palette index |
| clut_rgb | output | 24 | Colour palette RGB value |
| clut_clear | output | 1 | Clear the whole colour palette |

## Verification
The bench uses the default parameters: a 13-bit address, 12-bit width, height and cursor fields, 256 colour entries, 3 cursor colours and 512 pattern words. With these values the last pattern and palette entries, and the truncation of an oversized width write, can be reached directly. Every one of the eight depth codes is applied. The interrupt is driven through a pulse, a read and a same-cycle collision with a write, so each of its set and clear paths is observed at the pin.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  // byte offsets of the register map
  localparam int unsigned OFS_HDISP   = 32'h010;
  localparam int unsigned OFS_VDISP   = 32'h014;
  localparam int unsigned OFS_CTRL    = 32'h018;
  localparam int unsigned OFS_START   = 32'h01C;
  localparam int unsigned OFS_CPOS    = 32'h020;
  localparam int unsigned OFS_SRST    = 32'h024;
  localparam int unsigned OFS_TIM_LO  = 32'h040;
  localparam int unsigned OFS_TIM_HI  = 32'h07C;
  localparam int unsigned BASE_CPAL   = 32'h100;
  localparam int unsigned BASE_CLUT   = 32'h800;
  localparam int unsigned BASE_CPAT   = 32'h1000;
  localparam int unsigned ENTRY_BYTES = 8;
  localparam logic [1:0]  SIZE_WORD   = 2'd2;

  typedef enum logic [3:0] {
    RG_NONE, RG_HDISP, RG_VDISP, RG_CTRL, RG_START, RG_CPOS,
    RG_SRST, RG_TIMING, RG_CPAL, RG_CLUT, RG_CPAT
  } region_e;

  function automatic logic [31:0] hdisp_to_width(input logic [31:0] v);
    return v << 2;
  endfunction

  function automatic logic [31:0] width_to_hdisp(input logic [31:0] w);
    return w >> 2;
  endfunction

  function automatic logic [31:0] vdisp_to_height(input logic [31:0] v);
    return v >> 1;
  endfunction

  function automatic logic [31:0] height_to_vdisp(input logic [31:0] h);
    return h << 1;
  endfunction

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
  import dispctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IDX_W     = 9,
  parameter int CPAL_N    = 3,
  parameter int CLUT_N    = 256,
  parameter int PAT_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              acc_ok_o
);

  localparam int unsigned CPAL_END = BASE_CPAL + CPAL_N * ENTRY_BYTES;
  localparam int unsigned CLUT_END = BASE_CLUT + CLUT_N * ENTRY_BYTES;
  localparam int unsigned CPAT_END = BASE_CPAT + PAT_WORDS * ENTRY_BYTES;

  logic [31:0] a;
  logic [31:0] off;
  logic [31:0] ent;

  assign a   = 32'(addr_i);
  assign ent = off >> 3;
  assign idx_o    = ent[IDX_W-1:0];
  assign acc_ok_o = (size_i == SIZE_WORD) && (addr_i[1:0] == 2'b00);

  always_comb begin
    region_o = RG_NONE;
    off      = '0;
    if (a >= BASE_CPAL && a < CPAL_END) begin
      region_o = RG_CPAL;
      off      = a - BASE_CPAL;
    end else if (a >= BASE_CLUT && a < CLUT_END) begin
      region_o = RG_CLUT;
      off      = a - BASE_CLUT;
    end else if (a >= BASE_CPAT && a < CPAT_END) begin
      region_o = RG_CPAT;
      off      = a - BASE_CPAT;
    end else if (a >= OFS_TIM_LO && a <= OFS_TIM_HI) begin
      region_o = RG_TIMING;
    end else begin
      case (a)
        OFS_HDISP: region_o = RG_HDISP;
        OFS_VDISP: region_o = RG_VDISP;
        OFS_CTRL:  region_o = RG_CTRL;
        OFS_START: region_o = RG_START;
        OFS_CPOS:  region_o = RG_CPOS;
        OFS_SRST:  region_o = RG_SRST;
        default:   region_o = RG_NONE;
      endcase
    end
  end

  logic unused_ent;
  assign unused_ent = ^ent[31:IDX_W];

  AST_CPAL_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o == RG_CPAL) |-> (32'(idx_o) < CPAL_N)); // R5

endmodule

// File: rtl/dispctl_curmem.sv
module dispctl_curmem #(
  parameter int IDX_W     = 9,
  parameter int CPAL_N    = 3,
  parameter int PAT_WORDS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pal_we_i,
  input  logic             pat_we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [23:0]      pal_wdata_i,
  input  logic [15:0]      pat_wdata_i,
  output logic [23:0]      pal_rd_o,
  output logic [15:0]      pat_rd_o
);

  localparam int CPAL_IW = $clog2(CPAL_N);
  localparam int PAT_IW  = $clog2(PAT_WORDS);

  logic [23:0] cpal [CPAL_N];
  logic [15:0] cpat [PAT_WORDS];

  logic [CPAL_IW-1:0] pidx;
  logic [PAT_IW-1:0]  tidx;

  assign pidx = idx_i[CPAL_IW-1:0];
  assign tidx = idx_i[PAT_IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CPAL_N; i++) cpal[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < CPAL_N; i++) cpal[i] <= '0;
    end else if (pal_we_i && (32'(pidx) < CPAL_N)) begin
      cpal[pidx] <= pal_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAT_WORDS; i++) cpat[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < PAT_WORDS; i++) cpat[i] <= '0;
    end else if (pat_we_i) begin
      cpat[tidx] <= pat_wdata_i;
    end
  end

  assign pal_rd_o = (32'(pidx) < CPAL_N) ? cpal[pidx] : '0;
  assign pat_rd_o = cpat[tidx];

  logic unused_idx;
  assign unused_idx = ^idx_i;

  AST_PAL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we_i && !clr_i && (32'(pidx) < CPAL_N)) |=> (cpal[$past(pidx)] == $past(pal_wdata_i))); // R5

endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_o <= 1'b0;
    else if (set_i)  irq_o <= 1'b1;
    else if (clr_i)  irq_o <= 1'b0;
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o); // R10

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o); // R10

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(irq_o)); // R11

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int WID_W     = 12,
  parameter int HGT_W     = 12,
  parameter int CUR_W     = 12,
  parameter int CPAL_N    = 3,
  parameter int CLUT_N    = 256,
  parameter int PAT_WORDS = 512,
  localparam int CLUT_IW  = $clog2(CLUT_N),
  localparam int PAT_IW   = $clog2(PAT_WORDS),
  localparam int IDX_W    = (PAT_IW > CLUT_IW) ? PAT_IW : CLUT_IW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  input  logic               frame_done,
  output logic               irq,
  output logic [WID_W-1:0]   scr_width,
  output logic [HGT_W-1:0]   scr_height,
  output logic [31:0]        scr_start,
  output logic [31:0]        ctrl_word,
  output logic [4:0]         pix_depth,
  output logic [CUR_W-1:0]   cur_x,
  output logic [CUR_W-1:0]   cur_y,
  output logic               clut_we,
  output logic [CLUT_IW-1:0] clut_idx,
  output logic [23:0]        clut_rgb,
  output logic               clut_clear
);

  // decode
  region_e          dec_region;
  logic [IDX_W-1:0] dec_idx;
  logic             acc_ok;

  dispctl_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CPAL_N(CPAL_N),
    .CLUT_N(CLUT_N), .PAT_WORDS(PAT_WORDS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr_i(req_addr), .size_i(req_size),
    .region_o(dec_region), .idx_o(dec_idx), .acc_ok_o(acc_ok)
  );

  // named write events
  logic wr_ok, srst_hit, clut_hit, cpal_hit, cpat_hit;
  assign wr_ok    = req_valid && req_write && acc_ok;
  assign srst_hit = wr_ok && (dec_region == RG_SRST);
  assign clut_hit = wr_ok && (dec_region == RG_CLUT);
  assign cpal_hit = wr_ok && (dec_region == RG_CPAL);
  assign cpat_hit = wr_ok && (dec_region == RG_CPAT);

  // cursor storage
  logic [23:0] pal_rd;
  logic [15:0] pat_rd;

  dispctl_curmem #(
    .IDX_W(IDX_W), .CPAL_N(CPAL_N), .PAT_WORDS(PAT_WORDS)
  ) u_curmem (
    .clk(clk), .rst_n(rst_n), .clr_i(srst_hit),
    .pal_we_i(cpal_hit), .pat_we_i(cpat_hit), .idx_i(dec_idx),
    .pal_wdata_i(req_wdata[23:0]), .pat_wdata_i(req_wdata[15:0]),
    .pal_rd_o(pal_rd), .pat_rd_o(pat_rd)
  );

  // interrupt
  dispctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(frame_done), .clr_i(wr_ok), .irq_o(irq)
  );

  // scaled geometry values
  logic [31:0] width_new, height_new, hdisp_rd, vdisp_rd;
  assign width_new  = hdisp_to_width(req_wdata);
  assign height_new = vdisp_to_height(req_wdata);
  assign hdisp_rd   = width_to_hdisp(32'(scr_width));
  assign vdisp_rd   = height_to_vdisp(32'(scr_height));

  // register state
  logic [31:0] cpos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_width  <= '0;
      scr_height <= '0;
      scr_start  <= '0;
      ctrl_word  <= '0;
      cpos_q     <= '0;
    end else if (srst_hit) begin
      scr_width  <= '0;
      scr_height <= '0;
      scr_start  <= '0;
      ctrl_word  <= '0;
      cpos_q     <= '0;
    end else if (wr_ok) begin
      case (dec_region)
        RG_HDISP: scr_width  <= width_new[WID_W-1:0];
        RG_VDISP: scr_height <= height_new[HGT_W-1:0];
        RG_CTRL:  ctrl_word  <= req_wdata;
        RG_START: scr_start  <= req_wdata;
        RG_CPOS:  cpos_q     <= req_wdata;
        default:  ;
      endcase
    end
  end

  assign pix_depth = depth_of(ctrl_word[22:20]);
  assign cur_y     = cpos_q[CUR_W-1:0];
  assign cur_x     = cpos_q[2*CUR_W-1:CUR_W];

  // colour palette strobe and clear pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clut_we    <= 1'b0;
      clut_idx   <= '0;
      clut_rgb   <= '0;
      clut_clear <= 1'b0;
    end else begin
      clut_we    <= clut_hit;
      clut_clear <= srst_hit;
      if (clut_hit) begin
        clut_idx <= dec_idx[CLUT_IW-1:0];
        clut_rgb <= req_wdata[23:0];
      end
    end
  end

  // read path
  logic [31:0] rd_mux;
  always_comb begin
    case (dec_region)
      RG_HDISP: rd_mux = hdisp_rd;
      RG_VDISP: rd_mux = vdisp_rd;
      RG_CTRL:  rd_mux = ctrl_word;
      RG_CPAL:  rd_mux = 32'(pal_rd);
      RG_CPAT:  rd_mux = 32'(pat_rd);
      default:  rd_mux = '0;
    endcase
    if (!acc_ok) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  logic unused_cpos;
  assign unused_cpos = ^cpos_q[31:2*CUR_W];

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12

  AST_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R12

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (scr_width == '0 && scr_height == '0 && scr_start == '0 &&
                  ctrl_word == '0 && cur_x == '0 && cur_y == '0 && clut_clear)); // R9

  AST_CLUT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    clut_we |=> (!clut_we || $past(clut_hit))); // R4

  AST_BADSIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> ($stable(ctrl_word) && $stable(scr_width) &&
                                $stable(scr_height) && !clut_we)); // R11

  AST_DEPTH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[22:21] == 2'b11) |-> (pix_depth == 5'd0)); // R3

  AST_TIMING_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && dec_region == RG_TIMING) |=> ($stable(ctrl_word) && $stable(scr_start) &&
                                            $stable(scr_width) && !clut_we)); // R7

endmodule

// File: tb/tb_dispctl_regs.sv
module tb_dispctl_regs;

  localparam int CLK_PERIOD = 10;

  localparam logic [12:0] A_HDISP = 13'h010;
  localparam logic [12:0] A_VDISP = 13'h014;
  localparam logic [12:0] A_CTRL  = 13'h018;
  localparam logic [12:0] A_START = 13'h01C;
  localparam logic [12:0] A_CPOS  = 13'h020;
  localparam logic [12:0] A_SRST  = 13'h024;
  localparam logic [12:0] A_TIM0  = 13'h040;
  localparam logic [12:0] A_TIM1  = 13'h07C;
  localparam logic [12:0] A_CPAL  = 13'h100;
  localparam logic [12:0] A_CLUT  = 13'h800;
  localparam logic [12:0] A_CPAT  = 13'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        frame_done = 1'b0;
  logic        rsp_valid, irq, clut_we, clut_clear;
  logic [31:0] rsp_rdata, scr_start, ctrl_word;
  logic [11:0] scr_width, scr_height, cur_x, cur_y;
  logic [4:0]  pix_depth;
  logic [7:0]  clut_idx;
  logic [23:0] clut_rgb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .frame_done(frame_done),
    .irq(irq), .scr_width(scr_width), .scr_height(scr_height),
    .scr_start(scr_start), .ctrl_word(ctrl_word), .pix_depth(pix_depth),
    .cur_x(cur_x), .cur_y(cur_y), .clut_we(clut_we), .clut_idx(clut_idx),
    .clut_rgb(clut_rgb), .clut_clear(clut_clear)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_size = 2'd2;
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9 reset width", 32'(scr_width), 0);
    chk("R9 reset height", 32'(scr_height), 0);
    chk("R9 reset ctrl", ctrl_word, 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R12 idle rsp_valid", 32'(rsp_valid), 0);
    chk("R3 reset depth", 32'(pix_depth), 1);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(A_HDISP, 32'h140);
    chk("R1 width", 32'(scr_width), 32'h500);
    rd(A_HDISP, d);
    chk("R1 width read", d, 32'h140);
    wr(A_HDISP, 32'hFFF);
    chk("R1 width truncated", 32'(scr_width), 32'hFFC);
    rd(A_HDISP, d);
    chk("R1 width truncated read", d, 32'h3FF);
  endtask

  task automatic t_height();
    logic [31:0] d;
    wr(A_VDISP, 32'h3C1);
    chk("R2 height", 32'(scr_height), 32'h1E0);
    rd(A_VDISP, d);
    chk("R2 height read", d, 32'h3C0);
  endtask

  task automatic t_depth();
    int exp_d [8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    logic [31:0] d;
    for (int c = 0; c < 8; c++) begin
      wr(A_CTRL, (32'(c) << 20) | 32'h0000_0400);
      chk($sformatf("R3 depth code %0d", c), 32'(pix_depth), 32'(exp_d[c]));
    end
    wr(A_CTRL, 32'hA5C3_5A0F);
    rd(A_CTRL, d);
    chk("R6 ctrl read", d, 32'hA5C3_5A0F);
  endtask

  task automatic t_clut();
    logic [31:0] d;
    wr(A_CLUT + 13'd40, 32'hAB12_3456);
    chk("R4 clut_we", 32'(clut_we), 1);
    chk("R4 clut_idx", 32'(clut_idx), 5);
    chk("R4 clut_rgb", 32'(clut_rgb), 32'h12_3456);
    @(negedge clk);
    chk("R4 clut_we one cycle", 32'(clut_we), 0);
    wr(13'hFFC, 32'h00FF_0080);
    chk("R4 clut last idx", 32'(clut_idx), 255);
    chk("R4 clut last rgb", 32'(clut_rgb), 32'hFF_0080);
    rd(A_CLUT + 13'd40, d);
    chk("R4 clut read zero", d, 0);
  endtask

  task automatic t_cursor();
    logic [31:0] d;
    wr(A_CPAL + 13'd16, 32'hCCFF_8001);
    rd(A_CPAL + 13'd16, d);
    chk("R5 cursor palette 2", d, 32'h00FF_8001);
    rd(A_CPAL + 13'd20, d);
    chk("R5 cursor palette alias", d, 32'h00FF_8001);
    rd(A_CPAL, d);
    chk("R5 cursor palette 0 untouched", d, 0);
    wr(A_CPAT + 13'd4088, 32'hDEAD_BEEF);
    rd(A_CPAT + 13'd4088, d);
    chk("R5 pattern last", d, 32'h0000_BEEF);
    rd(A_CPAT + 13'd4092, d);
    chk("R5 pattern alias", d, 32'h0000_BEEF);
    wr(A_CPAT, 32'h0000_1234);
    rd(A_CPAT, d);
    chk("R5 pattern first", d, 32'h0000_1234);
  endtask

  task automatic t_position();
    logic [31:0] d;
    wr(A_START, 32'h0001_2345);
    wr(A_CPOS, (32'h123 << 12) | 32'h045);
    chk("R6 start", scr_start, 32'h0001_2345);
    chk("R6 cur_x", 32'(cur_x), 32'h123);
    chk("R6 cur_y", 32'(cur_y), 32'h045);
    rd(A_START, d);
    chk("R6 start read zero", d, 0);
    rd(A_CPOS, d);
    chk("R6 cpos read zero", d, 0);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    logic [31:0] c0, s0;
    logic [11:0] w0;
    c0 = ctrl_word; s0 = scr_start; w0 = scr_width;
    wr(A_TIM0, 32'hFFFF_FFFF);
    chk("R7 timing no strobe", 32'(clut_we), 0);
    wr(A_TIM1, 32'hFFFF_FFFF);
    chk("R7 timing ctrl", ctrl_word, c0);
    chk("R7 timing start", scr_start, s0);
    chk("R7 timing width", 32'(scr_width), 32'(w0));
    rd(A_TIM0, d);
    chk("R7 timing read", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(13'h200, d);
    chk("R8 unmapped 0x200", d, 0);
    rd(13'h000, d);
    chk("R8 unmapped 0x000", d, 0);
    rd(A_SRST, d);
    chk("R8 soft reset read", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse_frame();
    chk("R10 irq set", 32'(irq), 1);
    rd(A_CTRL, d);
    chk("R10 read keeps irq", 32'(irq), 1);
    wr(A_TIM0, 32'h0);
    chk("R10 write clears irq", 32'(irq), 0);
    frame_done = 1'b1;
    wr(A_TIM0, 32'h0);
    frame_done = 1'b0;
    chk("R10 collision sets irq", 32'(irq), 1);
  endtask

  task automatic t_badsize();
    logic [31:0] d;
    logic [31:0] c0;
    c0 = ctrl_word;
    wr(A_CTRL, 32'h1234_5678, 2'd1);
    chk("R11 half write ctrl", ctrl_word, c0);
    chk("R11 half write irq", 32'(irq), 1);
    wr(A_CTRL + 13'd2, 32'h1234_5678);
    chk("R11 misaligned irq", 32'(irq), 1);
    chk("R11 misaligned ctrl", ctrl_word, c0);
    wr(A_CLUT, 32'h00AA_BBCC, 2'd0);
    chk("R11 byte clut no strobe", 32'(clut_we), 0);
    rd(A_CTRL, d, 2'd1);
    chk("R11 half read zero", d, 0);
    @(negedge clk);
    chk("R12 rsp_valid drops", 32'(rsp_valid), 0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    pulse_frame();
    wr(A_SRST, 32'h0);
    chk("R9 srst clut_clear", 32'(clut_clear), 1);
    chk("R9 srst width", 32'(scr_width), 0);
    chk("R9 srst height", 32'(scr_height), 0);
    chk("R9 srst ctrl", ctrl_word, 0);
    chk("R9 srst start", scr_start, 0);
    chk("R9 srst cursor", {cur_x, cur_y}, 0);
    chk("R9 srst irq", 32'(irq), 0);
    rd(A_CPAL + 13'd16, d);
    chk("R9 srst cursor palette", d, 0);
    rd(A_CPAT + 13'd4088, d);
    chk("R9 srst pattern", d, 0);
    chk("R9 clut_clear one cycle", 32'(clut_clear), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_width();
    t_height();
    t_depth();
    t_clut();
    t_cursor();
    t_position();
    t_timing();
    t_unmapped();
    t_irq();
    t_badsize();
    t_srst();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule